// File: doc/BRIEF.md
# Descriptor Chain Walker for a DMA Channel

This block lets one DMA channel run a sequence of transfers from a chain of command records held in memory. When list mode is switched on, the walker reads a record of eight 32-bit words from the current node address. It reads them one word at a time through a plain word-read port, and the words overwrite the channel's command words. The walker then gives the transfer sequencer a one-cycle start pulse and waits for that command to finish. When it finishes, the walker takes the next-node pointer from the record it just loaded and repeats.

The record has the same layout as the channel's command words, so loading a record only overwrites them. A zero next-node pointer ends the chain. A pointer that leads back to an earlier node makes the chain cyclic, and it then runs until a cancel stops it. The walker sends single-cycle pulses to the channel's event counter. One pulse marks that the list has been loaded, and one more follows each finished command.

Top module: `list_walker`

## Requirements
- R1: While reset is held and on the first cycle after reset, `busy`, `mem_req`, `cmd_start` and `evt_o` are all low.
- R2: A record fetch makes eight accepted reads at node, node+4, …, node+28 in that order. A read is accepted in a cycle where `mem_req` and `mem_ack` are both high, and `mem_rdata` is taken in that same cycle.
- R3: The word read from node+4k is placed in slice k of `cmd_words` (bits 32k+31 down to 32k). Word 0 is general configuration, 1 is read-port configuration, 2 is read address, 3 is write address, 4 is transfer size, 5 is the next-node pointer, 6 is commands-done and 7 is control/status.
- R4: For the first record of a list, `evt_o` pulses in the same cycle as the first `cmd_start` (the list-loaded event). Records fetched later in the same list raise no event of their own.
- R5: Each `cmd_done` seen while a command is running gives exactly one `evt_o` pulse, in the cycle after `cmd_done`.
- R6: If the finished record's next-node pointer (word 5) is zero, `busy` falls together with the completion event and no further reads are made.
- R7: A non-zero next-node pointer starts a fetch at that address in the cycle after `cmd_done`. A pointer back to an earlier node repeats the chain without end.
- R8: A `cancel` in any state leaves the walker idle on the next cycle, with `busy` and `mem_req` low. A fetch that is in progress is dropped and gives no `cmd_start` and no event.
- R9: `cmd_start` is a one-cycle pulse. It rises only in the cycle after the eighth word of a record has been accepted.
- R10: Node addresses are word aligned. The two low bits of `head_addr` and of the next-node pointer are ignored, so `mem_addr[1:0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | List-enable pulse; starts a walk at `head_addr` when idle |
| head_addr | input | AW | Address of the first node |
| cancel | input | 1 | Stops the walk and clears list mode |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| cmd_words | output | 8*DW | Loaded command words, word k in slice k |
| cmd_start | output | 1 | One-cycle start pulse to the transfer sequencer |
| cmd_done | input | 1 | Pulse from the sequencer when the command finishes |
| evt_o | output | 1 | One-cycle event pulse to the event counter |
| busy | output | 1 | List mode active |

## Verification
The list-loaded event and the first start are due together, one cycle after the eighth accepted read. A completion event is due one cycle after `cmd_done`, and the next fetch request starts in that same cycle. After a cancel, `busy` and `mem_req` must be low at the next sample point. The bench samples only at falling edges. It keeps every expected read address, event and start in queue order, so a pulse that arrives a cycle early or late meets the wrong queue entry or an empty queue and is reported.

// File: rtl/list_walker.sv
module list_walker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int NEXT  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [AW-1:0]       head_addr,
  input  logic                cancel,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_ack,
  input  logic [DW-1:0]       mem_rdata,
  output logic [WORDS*DW-1:0] cmd_words,
  output logic                cmd_start,
  input  logic                cmd_done,
  output logic                evt_o,
  output logic                busy
);
  localparam int IW = $clog2(WORDS);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_GO, S_WAIT} state_t;

  state_t        state;
  logic [IW-1:0] idx;
  logic [AW-1:0] node_q;
  logic          first_q;
  logic [DW-1:0] words [WORDS];

  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = node_q + {{(AW-IW-2){1'b0}}, idx, 2'b00};
  assign cmd_start = (state == S_GO);
  assign busy      = (state != S_IDLE);

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign cmd_words[g*DW +: DW] = words[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      node_q  <= '0;
      first_q <= 1'b0;
      evt_o   <= 1'b0;
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else begin
      evt_o <= 1'b0;
      if (cancel) begin
        state   <= S_IDLE;
        first_q <= 1'b0;
        idx     <= '0;
      end else begin
        case (state)
          S_IDLE: if (go) begin
            node_q  <= head_addr & ALIGN;
            idx     <= '0;
            first_q <= 1'b1;
            state   <= S_FETCH;
          end
          S_FETCH: if (mem_ack) begin
            words[idx] <= mem_rdata;
            idx        <= idx + 1'b1;
            if (idx == LAST) begin
              state   <= S_GO;
              evt_o   <= first_q;
              first_q <= 1'b0;
            end
          end
          S_GO: state <= S_WAIT;
          S_WAIT: if (cmd_done) begin
            evt_o <= 1'b1;
            idx   <= '0;
            if (words[NEXT][AW-1:0] == '0) begin
              state <= S_IDLE;
            end else begin
              node_q <= words[NEXT][AW-1:0] & ALIGN;
              state  <= S_FETCH;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !cancel && idx != LAST) |=> mem_addr == $past(mem_addr) + AW'(4));

  p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  p_start_after_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_start) |-> $past(mem_req && mem_ack));

  p_cancel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!busy && !mem_req && !cmd_start));

  p_done_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req && !cmd_start && cmd_done && !cancel) |=> evt_o);
endmodule

// File: tb/tb_list_walker.sv
module tb_list_walker;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [AW-1:0] head_addr = '0;
  logic cancel = 1'b0;
  logic mem_req, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [8*DW-1:0] cmd_words;
  logic cmd_start, evt_o, busy;
  logic cmd_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  logic [31:0] mem [0:255];

  typedef struct {
    bit          is_start;
    logic [255:0] w;
    string       req;
  } item_t;

  item_t       expq[$];
  logic [31:0] addrq[$];

  list_walker dut (
    .clk(clk), .rst_n(rst_n), .go(go), .head_addr(head_addr), .cancel(cancel),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_words(cmd_words), .cmd_start(cmd_start), .cmd_done(cmd_done),
    .evt_o(evt_o), .busy(busy)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_ack   = mem_req && (cyc % 3 != 2);
  assign mem_rdata = mem[mem_addr[9:2]];

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rec(input logic [31:0] base);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = mem[base[9:2] + k];
    return r;
  endfunction

  task automatic put_desc(input logic [31:0] base, input logic [31:0] rd, input logic [31:0] nxt);
    mem[base[9:2] + 0] = 32'hB000_0011;
    mem[base[9:2] + 1] = 32'h0000_0F02 ^ base;
    mem[base[9:2] + 2] = rd;
    mem[base[9:2] + 3] = rd ^ 32'h5A5A_0000;
    mem[base[9:2] + 4] = 32'h0000_003F + base;
    mem[base[9:2] + 5] = nxt;
    mem[base[9:2] + 6] = 32'h0;
    mem[base[9:2] + 7] = 32'h0000_0011;
  endtask

  task automatic exp_fetch(input logic [31:0] base);
    for (int k = 0; k < 8; k++) addrq.push_back(base + 32'(4*k));
  endtask

  task automatic exp_evt(input string req);
    item_t it;
    it.is_start = 1'b0; it.w = '0; it.req = req;
    expq.push_back(it);
  endtask

  task automatic exp_start(input logic [31:0] base);
    item_t it;
    it.is_start = 1'b1; it.w = rec(base); it.req = "R3";
    expq.push_back(it);
  endtask

  // Monitor: pops expected reads, events and starts as they appear.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done_flag) begin
        if (mem_req && mem_ack) begin
          if (addrq.size() == 0) check(1'b0, "R2/R6 unexpected read", 256'(mem_addr), '0);
          else begin
            logic [31:0] ea;
            ea = addrq.pop_front();
            check(mem_addr == ea, "R2", 256'(mem_addr), 256'(ea));
          end
        end
        if (evt_o) begin
          if (expq.size() == 0) check(1'b0, "R4/R5 unexpected event", 256'(1), '0);
          else begin
            item_t it;
            it = expq.pop_front();
            check(!it.is_start, it.req, 256'(1), 256'(it.is_start));
          end
        end
        if (cmd_start) begin
          if (expq.size() == 0) check(1'b0, "R9 unexpected start", cmd_words, '0);
          else begin
            item_t it;
            it = expq.pop_front();
            check(it.is_start && cmd_words == it.w, "R3/R9", cmd_words, it.w);
          end
        end
      end
    end
  end

  // Sequencer model: finishes a command three cycles after its start.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) cmd_done = 1'b1;
      end
      if (cmd_start) cnt = 3;
    end
  end

  task automatic finish_run;
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD*20000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  task automatic kick(input logic [31:0] h);
    @(negedge clk); head_addr = h; go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_idle;
    int n = 0;
    do begin @(negedge clk); n++; end while ((busy || expq.size() != 0) && n < 500);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !cmd_start && !evt_o, "R1 during reset",
          256'({busy, mem_req, cmd_start, evt_o}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req && !cmd_start && !evt_o, "R1 after reset",
          256'({busy, mem_req, cmd_start, evt_o}), '0);

    // Ending chain of three records (R4 R5 R6 R7).
    put_desc(32'h40, 32'h1000_0000, 32'h80);
    put_desc(32'h80, 32'h1000_4000, 32'hC0);
    put_desc(32'hC0, 32'h1000_8000, 32'h0);
    exp_fetch(32'h40); exp_evt("R4 list loaded"); exp_start(32'h40); exp_evt("R5 done");
    exp_fetch(32'h80); exp_start(32'h80); exp_evt("R5 done");
    exp_fetch(32'hC0); exp_start(32'hC0); exp_evt("R6 last done");
    kick(32'h40);
    wait_idle();
    repeat (5) @(negedge clk);
    check(!busy && !mem_req, "R6 idle after end", 256'({busy, mem_req}), '0);
    check(expq.size() == 0 && addrq.size() == 0, "R6 all items seen",
          256'(expq.size() + addrq.size()), '0);

    // Cyclic chain, cancelled in the middle of a fetch (R7 R8).
    put_desc(32'h100, 32'h2000_0000, 32'h140);
    put_desc(32'h140, 32'h2000_1000, 32'h100);
    exp_fetch(32'h100); exp_evt("R4 list loaded"); exp_start(32'h100); exp_evt("R5 done");
    exp_fetch(32'h140); exp_start(32'h140); exp_evt("R5 done");
    exp_fetch(32'h100); exp_start(32'h100); exp_evt("R7 loop done");
    exp_fetch(32'h140); exp_start(32'h140); exp_evt("R7 loop done");
    exp_fetch(32'h100);
    kick(32'h100);
    begin
      int k = 0;
      int n = 0;
      forever begin
        @(negedge clk); n++;
        if (cmd_start) k++;
        if ((k == 4 && mem_req) || n > 1000) break;
      end
    end
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    check(!busy && !mem_req, "R8 idle after cancel", 256'({busy, mem_req}), '0);
    addrq.delete();
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R8 no start after cancel", 256'(expq.size()), '0);
    check(!busy, "R8 stays idle", 256'(busy), '0);

    // Unaligned head, single record (R10).
    put_desc(32'h200, 32'h3000_0000, 32'h0);
    exp_fetch(32'h200); exp_evt("R4 list loaded"); exp_start(32'h200); exp_evt("R6 last done");
    kick(32'h203);
    wait_idle();
    repeat (3) @(negedge clk);
    check(expq.size() == 0 && addrq.size() == 0 && !busy, "R10 aligned fetch completed",
          256'(expq.size() + addrq.size()), '0);
    finish_run();
  end
endmodule